// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block keeps wall-clock time as a free-running count of seconds. It takes a slow reference clock (nominally 32.768 kHz) as a plain input, synchronizes it into the system clock domain, divides its rising edges down to one tick per second, and advances a counter on each tick. Software sets it up through a small write/read register port: a control word, a load value, a match value, an interrupt mask, a raw status bit and a write-one-to-clear register.

When an increment brings the count to the match value, a status bit latches and, if unmasked, drives the interrupt output. The counter starts from 1 the first time counting mode is selected after reset. It can be repositioned at any time by writing the load register. It wraps from all-ones to zero instead of reloading. A debug-halt input, together with two control bits, decides whether time keeps running while a debugger holds the processor.

Top module: `rtcsec_top`

## Requirements
- R1: The counter advances by exactly one for every PRESC_DIV synchronized rising edges of `ref_clk_i` while counting is permitted.
- R2: The first write to CTRL (address 0) that sets the mode bit (bit 1) after reset loads the counter with 1. Later writes that set the mode bit leave the count unchanged.
- R3: A write to LOAD (address 1) sets the count to the written value and clears the prescaler, so a full PRESC_DIV edges pass before the next increment.
- R4: After all-ones, the count wraps to 0 and continues upward. The LOAD value is not reused.
- R5: When an increment makes the count equal MATCH (address 2), the raw status bit (RIS, address 4, bit 0) sets. A load that writes the match value does not set it.
- R6: `irq_o` is high exactly while raw status and the mask bit (IMASK, address 3, bit 0) are both 1. MIS (address 6, bit 0) reads that masked value.
- R7: Writing 1 to bit 0 of ICR (address 5) clears raw status. Writing 0 leaves it unchanged.
- R8: No counting happens unless both the enable bit (CTRL bit 0) and the mode bit (CTRL bit 1) are set. Configuration writes with the enable bit clear do not start the counter.
- R9: While `dbg_halt_i` is high, with the stall bit (CTRL bit 3) set and the debug-run bit (CTRL bit 2) clear, both the count and the prescaler hold.
- R10: While `dbg_halt_i` is high, counting continues if the debug-run bit is set, or if neither the debug-run bit nor the stall bit is set.
- R11: If a match event and an ICR clear fall in the same cycle, raw status ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Slow reference clock, asynchronous to clk_i |
| dbg_halt_i | input | 1 | High while a debugger halts the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | CNT_W | Register read data (combinational) |
| count_o | output | CNT_W | Current seconds count |
| irq_o | output | 1 | Masked match interrupt |

## Verification
A table of load/match/duration sets covers several cases: a match reached after a few seconds, a match that lies behind the count and must not fire, a wrap through all-ones onto a match at zero, a crossing of the sign bit, a sub-second run, and a load that follows a partial second. The last two show whether the prescaler is truly cleared. Directed runs then cover each combination of halt, stall and debug-run, which separates freezing from counting. They also check counting with enable clear and a repeated mode selection, which separates the one-time load of 1 from later writes. A collision is timed so that the tick edge and the ICR write land in the same clock, which exposes the status priority.

// File: rtl/rtcsec_pkg.sv
package rtcsec_pkg;
   typedef enum logic [2:0] {
      RA_CTRL  = 3'd0,
      RA_LOAD  = 3'd1,
      RA_MATCH = 3'd2,
      RA_IMASK = 3'd3,
      RA_RIS   = 3'd4,
      RA_ICR   = 3'd5,
      RA_MIS   = 3'd6
   } reg_addr_e;

   localparam int CTRL_W      = 4;
   localparam int CB_ENABLE   = 0;
   localparam int CB_MODE     = 1;
   localparam int CB_DBG_RUN  = 2;
   localparam int CB_STALL    = 3;
endpackage

// File: rtl/rtcsec_sync_edge.sv
module rtcsec_sync_edge #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("rtcsec_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES:0] sh_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q <= '0;
      else         sh_q <= {sh_q[STAGES-1:0], async_i};
   end

   assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

   // R1: one detected edge never spans two clocks
   p_rise_single_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o |=> !rise_o);
endmodule

// File: rtl/rtcsec_prescaler.sv
module rtcsec_prescaler #(
   parameter int DIV = 32768
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic clr_i,
   input  logic step_i,
   output logic tick_o
);
   if (DIV < 2) begin : g_bad_div
      $error("rtcsec_prescaler: DIV must be at least 2");
   end

   localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [PW-1:0] LAST = PW'(DIV - 1);
   localparam bit POW2 = ((1 << PW) == DIV);

   logic [PW-1:0] cnt_q;

   assign tick_o = step_i && !clr_i && (cnt_q == LAST);

   if (POW2) begin : g_wrap_natural
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     cnt_q <= '0;
         else if (clr_i)  cnt_q <= '0;
         else if (step_i) cnt_q <= cnt_q + 1'b1;
      end
   end else begin : g_wrap_compare
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     cnt_q <= '0;
         else if (clr_i)  cnt_q <= '0;
         else if (step_i) cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
   end

   // R3: a clear always leaves the divider at its start
   p_clr_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> (cnt_q == '0));
   // R9: without a step the divider holds
   p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!step_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/rtcsec_counter.sv
module rtcsec_counter #(
   parameter int CNT_W = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] match_val_i,
   output logic [CNT_W-1:0] count_o,
   output logic             hit_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_nxt;

   assign cnt_nxt = cnt_q + 1'b1;
   assign hit_o   = tick_i && !load_i && (cnt_nxt == match_val_i);
   assign count_o = cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (tick_i) cnt_q <= cnt_nxt;
   end

   // R1: a tick adds exactly one
   p_inc_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !load_i) |=> (count_o == CNT_W'($past(count_o) + 1'b1)));
   // R4: all-ones wraps to zero
   p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !load_i && (&count_o)) |=> (count_o == '0));
   // R3: a load takes the written value
   p_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (count_o == $past(load_val_i)));
endmodule

// File: rtl/rtcsec_top.sv
module rtcsec_top
   import rtcsec_pkg::*;
#(
   parameter int CNT_W       = 32,
   parameter int PRESC_DIV   = 32768,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             ref_clk_i,
   input  logic             dbg_halt_i,
   input  logic             wr_en_i,
   input  logic [2:0]       wr_addr_i,
   input  logic [CNT_W-1:0] wr_data_i,
   input  logic [2:0]       rd_addr_i,
   output logic [CNT_W-1:0] rd_data_o,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);
   if (CNT_W < CTRL_W) begin : g_bad_width
      $error("rtcsec_top: CNT_W must hold the control word");
   end

   logic [CTRL_W-1:0] ctrl_q;
   logic [CNT_W-1:0]  load_q, match_q;
   logic              mask_q, status_q, seen_q;
   logic              we_ctrl, we_load, we_match, we_mask, icr_clr;
   logic              first_sel, ld_any, run, rise, step, tick, hit;
   logic [CNT_W-1:0]  ld_val;

   assign we_ctrl  = wr_en_i && (wr_addr_i == RA_CTRL);
   assign we_load  = wr_en_i && (wr_addr_i == RA_LOAD);
   assign we_match = wr_en_i && (wr_addr_i == RA_MATCH);
   assign we_mask  = wr_en_i && (wr_addr_i == RA_IMASK);
   assign icr_clr  = wr_en_i && (wr_addr_i == RA_ICR) && wr_data_i[0];

   assign first_sel = we_ctrl && wr_data_i[CB_MODE] && !seen_q;
   assign ld_any    = we_load || first_sel;
   assign ld_val    = we_load ? wr_data_i : CNT_W'(1);

   // halt blocks counting only with stall set and debug-run clear
   assign run  = ctrl_q[CB_ENABLE] && ctrl_q[CB_MODE] &&
                 (!dbg_halt_i || ctrl_q[CB_DBG_RUN] || !ctrl_q[CB_STALL]);
   assign step = rise && run;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ctrl_q  <= '0;
         load_q  <= '0;
         match_q <= '0;
         mask_q  <= 1'b0;
         seen_q  <= 1'b0;
      end else begin
         if (we_ctrl)   ctrl_q  <= wr_data_i[CTRL_W-1:0];
         if (we_load)   load_q  <= wr_data_i;
         if (we_match)  match_q <= wr_data_i;
         if (we_mask)   mask_q  <= wr_data_i[0];
         if (first_sel) seen_q  <= 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      status_q <= 1'b0;
      else if (hit)     status_q <= 1'b1;
      else if (icr_clr) status_q <= 1'b0;
   end

   rtcsec_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ref_clk_i), .rise_o(rise));

   rtcsec_prescaler #(.DIV(PRESC_DIV)) u_presc (
      .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(ld_any), .step_i(step),
      .tick_o(tick));

   rtcsec_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i(clk_i), .rst_ni(rst_ni), .load_i(ld_any), .load_val_i(ld_val),
      .tick_i(tick), .match_val_i(match_q), .count_o(count_o), .hit_o(hit));

   assign irq_o = status_q && mask_q;

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         RA_CTRL:  rd_data_o = CNT_W'(ctrl_q);
         RA_LOAD:  rd_data_o = load_q;
         RA_MATCH: rd_data_o = match_q;
         RA_IMASK: rd_data_o = CNT_W'(mask_q);
         RA_RIS:   rd_data_o = CNT_W'(status_q);
         RA_MIS:   rd_data_o = CNT_W'(irq_o);
         default:  rd_data_o = '0;
      endcase
   end

   // R2: the one-time mode entry leaves the count at 1
   p_first_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(seen_q) |-> (count_o == CNT_W'(1)));
   // R5: status only rises on reaching the match value
   p_rise_match_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(status_q) |-> (count_o == match_q));
   // R7: a clear without a hit empties status
   p_icr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (icr_clr && !hit) |=> !status_q);
   // R11: a hit wins over a same-cycle clear
   p_hit_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (icr_clr && hit) |=> status_q);
   // R8: no counting with enable clear
   p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[CB_ENABLE] && !ld_any) |=> $stable(count_o));
   // R9: halted with stall and no debug-run freezes the count
   p_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dbg_halt_i && ctrl_q[CB_STALL] && !ctrl_q[CB_DBG_RUN] && !ld_any)
      |=> $stable(count_o));
endmodule

// File: tb/rtcsec_top_tb_top.sv
module rtcsec_top_tb_top;
   localparam int W   = 32;
   localparam int DIV = 4;
   localparam int VW  = 32 + 32 + 8 + 32 + 1;
   localparam int NV  = 7;

   // {load, match, ref pulses, expected count, expected RIS}
   localparam logic [VW-1:0] VEC [NV] = '{
      {32'd10,         32'd13,         8'd12, 32'd13,         1'b1},
      {32'd100,        32'd50,         8'd8,  32'd102,        1'b0},
      {32'hFFFF_FFFE,  32'd0,          8'd8,  32'd0,          1'b1},
      {32'h7FFF_FFFF,  32'h8000_0001,  8'd4,  32'h8000_0000,  1'b0},
      {32'd5,          32'd6,          8'd3,  32'd5,          1'b0},
      {32'd20,         32'd0,          8'd2,  32'd20,         1'b0},
      {32'd30,         32'd0,          8'd2,  32'd30,         1'b0}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ref_clk = 1'b0;
   logic          halt = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [W-1:0]  rd_data, count;
   logic          irq;
   int            checks = 0;
   int            failures = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   rtcsec_top #(.CNT_W(W), .PRESC_DIV(DIV), .SYNC_STAGES(2)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .dbg_halt_i(halt),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data), .count_o(count), .irq_o(irq));

   task automatic check(input string req, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); ref_clk = 1'b1;
         repeat (4) @(negedge clk);
         ref_clk = 1'b0;
         repeat (4) @(negedge clk);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      check("R2 reset count", count, '0);
      rd(3'd4, r); check("R5 reset RIS", r, '0);
      check("R6 reset irq", {31'd0, irq}, '0);

      // R8: mode selected, enable clear: first load of 1, no counting
      wr(3'd0, 32'h2);
      check("R2 first mode load", count, 32'd1);
      pulses(8);
      check("R8 no count while disabled", count, 32'd1);
      wr(3'd0, 32'h1);
      pulses(8);
      check("R8 enable without mode", count, 32'd1);
      wr(3'd0, 32'h3);
      pulses(4);
      check("R1 one tick per DIV edges", count, 32'd2);
      wr(3'd0, 32'h1);
      wr(3'd0, 32'h3);
      check("R2 no reload on reselect", count, 32'd2);

      // vector table
      for (int i = 0; i < NV; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         wr(3'd1, v[104:73]);
         wr(3'd2, v[72:41]);
         wr(3'd5, 32'h1);
         pulses(int'(v[40:33]));
         check("R1 R3 R4 table count", count, v[32:1]);
         rd(3'd4, r);
         check("R5 table RIS", r, {31'd0, v[0]});
      end

      // R5: load onto match does not set status
      wr(3'd2, 32'd77);
      wr(3'd1, 32'd77);
      rd(3'd4, r); check("R5 load onto match", r, '0);

      // R6/R7: mask and clear
      wr(3'd1, 32'd40); wr(3'd2, 32'd41); pulses(4);
      rd(3'd4, r); check("R5 match set", r, 32'd1);
      check("R6 masked irq low", {31'd0, irq}, '0);
      wr(3'd3, 32'h1);
      check("R6 unmasked irq high", {31'd0, irq}, 32'd1);
      rd(3'd6, r); check("R6 MIS", r, 32'd1);
      wr(3'd5, 32'h0);
      rd(3'd4, r); check("R7 write 0 no effect", r, 32'd1);
      wr(3'd5, 32'h1);
      rd(3'd4, r); check("R7 write 1 clears", r, '0);
      check("R6 irq drops", {31'd0, irq}, '0);

      // R11: match tick and clear in the same cycle
      wr(3'd1, 32'd200); wr(3'd2, 32'd201); pulses(3);
      @(negedge clk); ref_clk = 1'b1;
      @(negedge clk);
      @(negedge clk); wr_en = 1'b1; wr_addr = 3'd5; wr_data = 32'h1;
      @(negedge clk); wr_en = 1'b0; ref_clk = 1'b0;
      check("R11 count reached match", count, 32'd201);
      rd(3'd4, r); check("R11 hit beats clear", r, 32'd1);
      wr(3'd5, 32'h1);

      // R9/R10: debug halt
      halt = 1'b1;
      wr(3'd0, 32'hB); wr(3'd1, 32'd0); pulses(8);
      check("R9 stall freezes", count, 32'd0);
      wr(3'd0, 32'hF); wr(3'd1, 32'd0); pulses(8);
      check("R10 debug-run counts", count, 32'd2);
      wr(3'd0, 32'h3); wr(3'd1, 32'd0); pulses(4);
      check("R10 neither bit counts", count, 32'd1);
      wr(3'd0, 32'hB); pulses(2); halt = 1'b0; pulses(2);
      check("R9 prescaler held in stall", count, 32'd1);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule